// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Interface

This block connects a simple character terminal to a processor's load/store bus. It has two independent paths. A keyboard receiver takes a byte whenever the keyboard pulses its strobe. A display transmitter hands one byte at a time to the display and waits for the display to acknowledge it. Each path has a control word with a ready flag and a data word. Software polls the ready flag and then touches the data word. The device side raises the flags, and the processor's data accesses lower them.

The bus is word addressed. A read returns data combinationally in the cycle where `rd_en` is high. Any side effect of an access takes place at the rising clock edge that ends that cycle. There are four registers. The two address bits above the byte offset select one of them: index 0 is receiver control, 1 is receiver data, 2 is transmitter control and 3 is transmitter data. Reset is synchronous and active low.

Top module: `mmio_terminal`

## Requirements
- R1: During reset and after it, receiver control reads 0, receiver data reads 0, transmitter control reads 1 (ready), transmitter data reads 0, and `disp_valid` is 0.
- R2: A cycle with `kb_strobe` high stores `kb_data` in the receiver data register and sets the receiver ready flag, which is bit 0 of receiver control (offset 0x0).
- R3: A load from receiver data (offset 0x4) returns the stored byte in bits 7:0 and clears the receiver ready flag at the end of that cycle, unless a strobe arrives in the same cycle.
- R4: A strobe while the receiver ready flag is set and the byte is not being read in that cycle replaces the byte and sets a sticky overrun flag in bit 1 of receiver control. A load of receiver control still shows the flag in that cycle and clears it at the end of the cycle.
- R5: When a strobe and a receiver data load fall in the same cycle, the load returns the old byte. Afterwards the new byte is held, ready stays 1, and no overrun is flagged.
- R6: A store to transmitter data (offset 0xC) while transmitter ready (bit 0 at offset 0x8) is 1 puts the byte on `disp_data`, raises `disp_valid` and clears transmitter ready, all from the next cycle.
- R7: `disp_ack` while `disp_valid` is high sets transmitter ready again and drops `disp_valid` from the next cycle. `disp_ack` while `disp_valid` is low has no effect.
- R8: A store to transmitter data while transmitter ready is 0 is dropped. This holds even when `disp_ack` arrives in the same cycle. `disp_data` and the transmitter data readback keep the earlier byte.
- R9: Stores to either control register change nothing. Loads from transmitter data return the last byte accepted and change nothing.
- R10: Unused bits of every register read as 0, and `rdata` is 0 in any cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Byte address of the register word |
| rd_en | input | 1 | Load from the addressed register this cycle |
| wr_en | input | 1 | Store to the addressed register this cycle |
| wdata | input | 32 | Store data |
| rdata | output | 32 | Load data, valid while rd_en is high |
| kb_data | input | 8 | Byte from the keyboard |
| kb_strobe | input | 1 | One-cycle pulse that delivers kb_data |
| disp_data | output | 8 | Byte offered to the display |
| disp_valid | output | 1 | A byte is waiting for the display |
| disp_ack | input | 1 | The display has taken the offered byte |

## Verification
Two pairs of actions can land in the same clock cycle. The first pair is a keyboard strobe and a processor load of the receiver data word. The second pair is a display acknowledge and a store to the transmitter data word. The bench forces each pair by raising both inputs between the same two clock edges. It then judges the outcome through the bus: the load must return the old byte, and later reads must show the new byte with ready set and no overrun. On the transmit side, a transmitter readback must show that the store made while the transmitter was busy was dropped even though the acknowledge arrived with it.

// File: rtl/term_pkg.sv
// Package: shared register indices and control-bit positions for the
// terminal interface. Assumes a four-word register window.
package term_pkg;
    localparam int NUM_REGS = 4;
    localparam int RDY_BIT  = 0;
    localparam int OVR_BIT  = 1;

    typedef enum logic [1:0] {
        REG_RX_CTRL = 2'd0,
        REG_RX_DATA = 2'd1,
        REG_TX_CTRL = 2'd2,
        REG_TX_DATA = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/term_decode.sv
// Address decoder: turns a byte address plus the read/write enables into
// one-hot read and write selects, one per register word.
// Assumes word-aligned accesses; the byte-offset bits are ignored.
module term_decode #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     rd_en,
    input  logic                     wr_en,
    output logic [term_pkg::NUM_REGS-1:0] rd_hit,
    output logic [term_pkg::NUM_REGS-1:0] wr_hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic [1:0]       unused_byte_off;

    // Purpose: split the address into word index and ignored byte offset.
    always_comb begin
        word_idx        = addr[ADDR_W-1:2];
        unused_byte_off = addr[1:0];
    end

    for (genvar i = 0; i < term_pkg::NUM_REGS; i++) begin : g_sel
        // Purpose: raise the select of register i when its word is addressed.
        always_comb begin
            rd_hit[i] = rd_en && (word_idx == IDX_W'(i));
            wr_hit[i] = wr_en && (word_idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/term_rx_path.sv
// Receiver path: holds the last keyboard byte, the ready flag and the
// sticky overrun flag. A strobe always wins over a same-cycle data load;
// the load then counts as consuming the old byte, so no overrun is flagged.
// Assumes kb_strobe is a single-cycle pulse per byte.
module term_rx_path #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] kb_data,
    input  logic              kb_strobe,
    input  logic              rd_ctrl,
    input  logic              rd_data,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              rx_overrun
);
    // Purpose: capture bytes, track ready, and keep the overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte    <= '0;
            rx_ready   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (kb_strobe) begin
                rx_byte  <= kb_data;
                rx_ready <= 1'b1;
            end else if (rd_data) begin
                rx_ready <= 1'b0;
            end

            if (kb_strobe && rx_ready && !rd_data) begin
                rx_overrun <= 1'b1;
            end else if (rd_ctrl) begin
                rx_overrun <= 1'b0;
            end
        end
    end

    AST_RX_STROBE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        kb_strobe |=> (rx_ready && rx_byte == $past(kb_data))); // R2
    AST_RX_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !kb_strobe) |=> !rx_ready); // R3
    AST_RX_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_strobe && rx_ready && !rd_data) |=> rx_overrun); // R4
    AST_RX_RACE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_strobe && rd_data && !rx_overrun) |=> (rx_ready && !rx_overrun)); // R5
endmodule

// File: rtl/term_tx_path.sv
// Transmitter path: holds the byte offered to the display and the ready
// flag. A store is taken only while ready is 1. An acknowledge is taken only
// while a byte is pending. A store that arrives with the acknowledge is dropped.
module term_tx_path #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              disp_ack,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              tx_ready
);
    // Purpose: accept stores when ready and re-arm on display acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_ready <= 1'b1;
        end else if (!tx_ready) begin
            if (disp_ack) begin
                tx_ready <= 1'b1;
            end
        end else if (wr_data) begin
            tx_byte  <= wr_byte;
            tx_ready <= 1'b0;
        end
    end

    AST_TX_STORE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_ready) |=> (!tx_ready && tx_byte == $past(wr_byte))); // R6
    AST_TX_ACK_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_ack && !tx_ready) |=> tx_ready); // R7
    AST_TX_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready) |=> $stable(tx_byte)); // R8
endmodule

// File: rtl/term_readmux.sv
// Read multiplexer: assembles the selected register word, zero-extending
// every field. Drives zero when no read select is active.
module term_readmux #(
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic [term_pkg::NUM_REGS-1:0] rd_hit,
    input  logic                          rx_ready,
    input  logic                          rx_overrun,
    input  logic [CHAR_W-1:0]             rx_byte,
    input  logic                          tx_ready,
    input  logic [CHAR_W-1:0]             tx_byte,
    output logic [DATA_W-1:0]             rdata
);
    import term_pkg::*;

    // Purpose: pick the one addressed word, all other bits zero.
    always_comb begin
        rdata = '0;
        if (rd_hit[REG_RX_CTRL]) begin
            rdata[RDY_BIT] = rx_ready;
            rdata[OVR_BIT] = rx_overrun;
        end
        if (rd_hit[REG_RX_DATA]) begin
            rdata[CHAR_W-1:0] = rx_byte;
        end
        if (rd_hit[REG_TX_CTRL]) begin
            rdata[RDY_BIT] = tx_ready;
        end
        if (rd_hit[REG_TX_DATA]) begin
            rdata[CHAR_W-1:0] = tx_byte;
        end
    end
endmodule

// File: rtl/mmio_terminal.sv
// Top: memory-mapped keyboard/display terminal with polled handshaking.
// Word 0 receiver control, 1 receiver data, 2 transmitter control,
// 3 transmitter data. Reads are combinational; side effects happen at the
// closing clock edge. Assumes at most one of rd_en / wr_en per cycle.
module mmio_terminal #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CHAR_W-1:0] kb_data,
    input  logic              kb_strobe,
    output logic [CHAR_W-1:0] disp_data,
    output logic              disp_valid,
    input  logic              disp_ack
);
    import term_pkg::*;

    logic [NUM_REGS-1:0] rd_hit;
    logic [NUM_REGS-1:0] wr_hit;
    logic [CHAR_W-1:0]   rx_byte;
    logic                rx_ready;
    logic                rx_overrun;
    logic [CHAR_W-1:0]   tx_byte;
    logic                tx_ready;
    logic                unused_bits;

    term_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    term_rx_path #(.CHAR_W(CHAR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .kb_data    (kb_data),
        .kb_strobe  (kb_strobe),
        .rd_ctrl    (rd_hit[REG_RX_CTRL]),
        .rd_data    (rd_hit[REG_RX_DATA]),
        .rx_byte    (rx_byte),
        .rx_ready   (rx_ready),
        .rx_overrun (rx_overrun)
    );

    term_tx_path #(.CHAR_W(CHAR_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_hit[REG_TX_DATA]),
        .wr_byte  (wdata[CHAR_W-1:0]),
        .disp_ack (disp_ack),
        .tx_byte  (tx_byte),
        .tx_ready (tx_ready)
    );

    term_readmux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_rdmux (
        .rd_hit     (rd_hit),
        .rx_ready   (rx_ready),
        .rx_overrun (rx_overrun),
        .rx_byte    (rx_byte),
        .tx_ready   (tx_ready),
        .tx_byte    (tx_byte),
        .rdata      (rdata)
    );

    // Purpose: present the pending byte to the display.
    always_comb begin
        disp_data  = tx_byte;
        disp_valid = !tx_ready;
    end

    // Purpose: gather bits that control stores and upper data never use.
    always_comb begin
        unused_bits = ^{wr_hit[REG_RX_CTRL], wr_hit[REG_TX_CTRL], wr_hit[REG_RX_DATA],
                        wdata[DATA_W-1:CHAR_W]};
    end

    AST_CTRL_STORE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit[REG_TX_DATA] && !kb_strobe && !disp_ack)
        |=> ($stable(rx_ready) && $stable(tx_ready) && $stable(disp_data))); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0)); // R10
endmodule

// File: tb/mmio_terminal_tb.sv
module mmio_terminal_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  kb_data = '0;
    logic        kb_strobe = 1'b0;
    logic [7:0]  disp_data;
    logic        disp_valid;
    logic        disp_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        mon_ev;

    always #10 clk = ~clk;

    mmio_terminal u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .kb_data(kb_data), .kb_strobe(kb_strobe),
        .disp_data(disp_data), .disp_valid(disp_valid), .disp_ack(disp_ack)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected load data and compares with the bus.
    initial begin
        forever begin
            @(mon_ev);
            if (exp_q.size() == 0) begin
                check(32'hDEAD, 32'h0, "queue underflow");
            end else begin
                check(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Driver: one load cycle; starts just after a falling edge.
    task automatic bus_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #5 -> mon_ev;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] b);
        kb_data = b; kb_strobe = 1'b1;
        @(negedge clk);
        kb_strobe = 1'b0;
    endtask

    task automatic ack();
        disp_ack = 1'b1;
        @(negedge clk);
        disp_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        bus_rd(4'h8, 32'h1, "R1 tx ready in reset");
        rst_n = 1'b1;
        // R1 reset state
        bus_rd(4'h0, 32'h0, "R1 rx ctrl");
        bus_rd(4'h4, 32'h0, "R1 rx data");
        bus_rd(4'h8, 32'h1, "R1 tx ctrl");
        bus_rd(4'hC, 32'h0, "R1 tx data");
        check({31'd0, disp_valid}, 32'h0, "R1 disp_valid");
        // R10 idle bus reads zero
        #5 check(rdata, 32'h0, "R10 idle rdata");
        @(negedge clk);
        // R2 / R3
        strobe(8'h41);
        bus_rd(4'h0, 32'h1, "R2 rx ready set");
        bus_rd(4'h4, 32'h41, "R2 rx byte");
        bus_rd(4'h0, 32'h0, "R3 ready cleared by load");
        // R4 overrun
        strobe(8'h11);
        strobe(8'h22);
        bus_rd(4'h0, 32'h3, "R4 overrun shown");
        bus_rd(4'h0, 32'h1, "R4 overrun cleared");
        bus_rd(4'h4, 32'h22, "R4 newest byte kept");
        // R5 strobe coincides with data load
        strobe(8'h33);
        kb_data = 8'h44; kb_strobe = 1'b1;
        bus_rd(4'h4, 32'h33, "R5 load returns old byte");
        kb_strobe = 1'b0;
        bus_rd(4'h0, 32'h1, "R5 ready kept, no overrun");
        bus_rd(4'h4, 32'h44, "R5 new byte held");
        bus_rd(4'h0, 32'h0, "R5 consumed");
        // R9 control stores inert
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, 32'h0, "R9 rx ctrl store inert");
        bus_wr(4'h8, 32'h0);
        bus_rd(4'h8, 32'h1, "R9 tx ctrl store inert");
        // R6 transmit
        bus_wr(4'hC, 32'hABCD_005A);
        #5;
        check({31'd0, disp_valid}, 32'h1, "R6 disp_valid");
        check({24'd0, disp_data}, 32'h5A, "R6 disp_data");
        @(negedge clk);
        bus_rd(4'h8, 32'h0, "R6 tx ready cleared");
        bus_rd(4'hC, 32'h5A, "R9 tx data readback");
        bus_rd(4'h8, 32'h0, "R9 tx data load inert");
        // R8 store while busy
        bus_wr(4'hC, 32'h77);
        #5 check({24'd0, disp_data}, 32'h5A, "R8 busy store dropped");
        @(negedge clk);
        bus_rd(4'hC, 32'h5A, "R8 readback unchanged");
        // R7 acknowledge
        ack();
        #5 check({31'd0, disp_valid}, 32'h0, "R7 valid dropped");
        @(negedge clk);
        bus_rd(4'h8, 32'h1, "R7 tx ready set");
        ack();
        bus_rd(4'h8, 32'h1, "R7 stray ack inert");
        #5 check({31'd0, disp_valid}, 32'h0, "R7 stray ack valid");
        @(negedge clk);
        // R8 store coincides with ack
        bus_wr(4'hC, 32'h10);
        disp_ack = 1'b1;
        bus_wr(4'hC, 32'h20);
        disp_ack = 1'b0;
        bus_rd(4'h8, 32'h1, "R8 ack taken");
        bus_rd(4'hC, 32'h10, "R8 store with ack dropped");
        if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "queue drained");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule